// File: doc/BRIEF.md
# Self-Describing Word to Byte Stream Unpacker

This block turns 32-bit words into a stream of bytes. Each word says by itself how many bytes it holds, from one to four. A short word fills its unused upper bytes with fixed marker values, so no separate length field travels with the word. Each word also carries a small channel tag. Words arrive on a valid/ready input. Their bytes leave one per cycle on a valid/ready output, in order from the lowest byte upward. Every byte carries the tag of its word, and the final byte of each word raises a last flag.

The block holds one word at a time. It accepts a new word only when every byte of the previous word has been handed off. The length is decoded once, when the word is loaded. When the consumer keeps its ready high, the bytes of a word come out on consecutive cycles with no gap.

Top module: `word_byte_unpacker`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: When bits 31:8 of a word are 0x808080, the word yields exactly one byte, equal to bits 7:0.
- R3: Otherwise, when bits 31:16 are 0x8181, the word yields two bytes: bits 7:0, then bits 15:8.
- R4: Otherwise, when bits 31:24 are 0x82, the word yields three bytes: bits 7:0, then 15:8, then 23:16.
- R5: Any other word yields four bytes: bits 7:0, 15:8, 23:16 and 31:24, in that order.
- R6: in_ready is 1 only while no byte of an earlier word is still waiting. A word offered while in_ready is 0 is not taken, and it does not change the bytes being emitted.
- R7: Every emitted byte carries on out_tag the tag that came with its word.
- R8: out_last is 1 on the final byte of a word and 0 on every other byte. After that byte is taken, out_valid falls and in_ready rises.
- R9: While out_valid is 1 and out_ready is 0, out_byte, out_tag and out_last hold their values and out_valid stays 1.
- R10: When a byte that is not the last is taken, out_valid is 1 again in the next cycle, so a word drains in as many cycles as it has bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The block can take a word |
| in_word | input | 32 | Self-describing word |
| in_tag | input | TAG_W | Channel tag of the word |
| out_valid | output | 1 | A byte is presented |
| out_ready | input | 1 | The consumer takes the byte |
| out_byte | output | 8 | Current byte |
| out_tag | output | TAG_W | Tag of the word the byte came from |
| out_last | output | 1 | Current byte is the word's final byte |

## Verification
Several handshake rules are checked by assertions on every cycle. A stalled byte must hold steady. A byte that is not the last must be followed at once by another. Taking the last byte must free the input. A single-byte word must present its only byte as last. An accepted word must close the input. The bench's sweeps cover what the assertions cannot see: that the decoded length and the byte order match the marker rules. They sweep every value of the data byte and of the top byte around each marker pattern, and they check the tag on each byte. They also check that a word offered while the block is busy is neither taken nor allowed to corrupt the output.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int IDX_W  = $clog2(LANES);

  // Marker value filling the unused lanes of a word that carries k bytes.
  function automatic logic [LANE_W-1:0] marker_for(input int k);
    return LANE_W'(8'h80 + k - 1);
  endfunction

  // Lane number idx of a word, lane 0 being the lowest byte.
  function automatic logic [LANE_W-1:0] lane_of(input logic [WORD_W-1:0] w,
                                                input logic [IDX_W-1:0] idx);
    return w[LANE_W*idx +: LANE_W];
  endfunction
endpackage

// File: rtl/unpk_len_decode.sv
module unpk_len_decode
  import unpk_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  count
);
  // form_hit[k]: all lanes above k-1 hold the marker of a k-byte word
  logic [LANES-1:1] form_hit;

  for (genvar k = 1; k < LANES; k++) begin : g_form
    logic [LANES-1:k] lane_eq;
    for (genvar j = k; j < LANES; j++) begin : g_lane
      assign lane_eq[j] = (word[LANE_W*j +: LANE_W] == marker_for(k));
    end
    assign form_hit[k] = &lane_eq;
  end

  // Shortest form wins; no marker means a full word.
  always_comb begin
    count = CNT_W'(LANES);
    for (int k = LANES - 1; k >= 1; k--) begin
      if (form_hit[k]) count = CNT_W'(k);
    end
  end
endmodule

// File: rtl/unpk_lane_seq.sv
module unpk_lane_seq
  import unpk_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              advance,
  output logic              busy,
  output logic [LANE_W-1:0] cur_byte,
  output logic [TAG_W-1:0]  cur_tag,
  output logic              is_last
);
  logic [WORD_W-1:0] held_word;
  logic [CNT_W-1:0]  held_count;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  idx_plus1;

  assign idx_plus1 = CNT_W'(idx) + CNT_W'(1);
  assign is_last   = busy && (idx_plus1 == held_count);
  assign cur_byte  = lane_of(held_word, idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      idx        <= '0;
      held_word  <= '0;
      held_count <= '0;
      cur_tag    <= '0;
    end else if (load) begin
      busy       <= 1'b1;
      idx        <= '0;
      held_word  <= load_word;
      held_count <= load_count;
      cur_tag    <= load_tag;
    end else if (advance) begin
      if (is_last) busy <= 1'b0;
      else         idx  <= idx + IDX_W'(1);
    end
  end

  // R2: a one-byte word presents its byte as the last one
  a_r2_single_last: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_count == CNT_W'(1)) |=> (busy && is_last));

  // R5: the decoded length always lies in 1..LANES
  a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_count >= CNT_W'(1) && load_count <= CNT_W'(LANES)));
endmodule

// File: rtl/word_byte_unpacker.sv
module word_byte_unpacker
  import unpk_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LANE_W-1:0] out_byte,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_last
);
  logic             busy;
  logic             accept_ev;
  logic             take_ev;
  logic [CNT_W-1:0] dec_count;

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign accept_ev = in_valid && in_ready;
  assign take_ev   = out_valid && out_ready;

  unpk_len_decode u_dec (
    .word  (in_word),
    .count (dec_count)
  );

  unpk_lane_seq #(.TAG_W(TAG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept_ev),
    .load_word  (in_word),
    .load_tag   (in_tag),
    .load_count (dec_count),
    .advance    (take_ev),
    .busy       (busy),
    .cur_byte   (out_byte),
    .cur_tag    (out_tag),
    .is_last    (out_last)
  );

  // R6: an accepted word closes the input until it drains
  a_r6_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (out_valid && !in_ready));

  // R8: taking the final byte frees the block
  a_r8_last_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && out_last) |=> (!out_valid && in_ready));

  // R9: a stalled byte holds steady
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_byte) && $stable(out_tag) && $stable(out_last)));

  // R10: no bubble between bytes of one word
  a_r10_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && !out_last) |=> out_valid);

  // R7: the tag stays with the word across its bytes
  a_r7_tag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && !out_last) |=> $stable(out_tag));
endmodule

// File: tb/word_byte_unpacker_test.sv
module word_byte_unpacker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [3:0]  in_tag = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;
  logic [3:0]  out_tag;
  logic        out_last;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  word_byte_unpacker #(.TAG_W(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_tag(out_tag), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Length from the marker rules, tested byte by byte.
  function automatic int exp_len(input logic [31:0] w);
    logic [7:0] b3 = w[31:24], b2 = w[23:16], b1 = w[15:8];
    if (b3 == 8'h80 && b2 == 8'h80 && b1 == 8'h80) return 1;
    if (b3 == 8'h81 && b2 == 8'h81) return 2;
    if (b3 == 8'h82) return 3;
    return 4;
  endfunction

  function automatic string len_req(input int n);
    case (n)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_word(input logic [31:0] w, input logic [3:0] t,
                          input bit stall, input bit junk);
    int n = exp_len(w);
    @(negedge clk);
    chk(in_ready == 1'b1, "R6", 32'(in_ready), 1);
    in_valid = 1'b1; in_word = w; in_tag = t;
    @(negedge clk);
    if (junk) begin in_word = ~w; in_tag = ~t; end
    else in_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] eb = 8'((w >> (8 * k)) & 32'hff);
      if (stall) begin
        out_ready = 1'b0;
        chk(out_valid == 1'b1, "R9", 32'(out_valid), 1);
        @(negedge clk);
        chk(out_valid == 1'b1 && out_byte == eb, "R9", 32'(out_byte), 32'(eb));
      end
      out_ready = 1'b1;
      chk(out_valid == 1'b1, "R10", 32'(out_valid), 1);
      chk(in_ready == 1'b0, "R6", 32'(in_ready), 0);
      chk(out_byte == eb, len_req(n), 32'(out_byte), 32'(eb));
      chk(out_tag == t, "R7", 32'(out_tag), 32'(t));
      chk(out_last == (k == n - 1), "R8", 32'(out_last), 32'(k == n - 1));
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R8", {out_valid, in_ready}, 32'b01);
    if (junk) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6", 32'(out_valid), 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {out_valid, in_ready}, 32'b01);

    for (int b = 0; b < 256; b++)  // R2: one-byte form, every data value
      run_word({24'h808080, 8'(b)}, 4'(b), (b % 7) == 0, (b % 5) == 0);
    for (int b = 0; b < 256; b++)  // R3: two-byte form
      run_word({16'h8181, 8'(b), 8'(255 - b)}, 4'(b + 3), (b % 6) == 1, (b % 9) == 2);
    for (int b = 0; b < 256; b++)  // R4: three-byte form
      run_word({8'h82, 8'(b), 8'(b ^ 8'h5a), 8'(b + 1)}, 4'(b + 7), (b % 4) == 3, (b % 8) == 5);
    for (int b = 0; b < 256; b++)  // R2/R4/R5: top byte swept next to one-byte markers
      run_word({8'(b), 16'h8080, 8'h5a}, 4'(b >> 4), (b % 3) == 0, 1'b0);
    for (int b = 0; b < 256; b++)  // R3/R4/R5: top byte swept next to two-byte markers
      run_word({8'(b), 8'h81, 8'h33, 8'h44}, 4'(b), (b % 5) == 2, (b % 11) == 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule